// File: doc/BRIEF.md
# Flash Read-Data Responder

This block forms the data returned for every read of a parallel NOR flash model. A separate command sequencer tracks unlock and command writes and hands this block its current command code, a flag saying whether a write sequence is in progress, and the status byte it wants reported. On each read strobe the responder selects one of four data sources: plain array bytes, identification words, a polled status byte whose bit 6 flips on every status read, or a byte from a small query table that is built from parameters. It returns the selected data one cycle later, together with a valid strobe.

The array itself sits outside the block. The caller presents the four bytes starting at the read address on `arr_bytes`, with lane k holding the byte at address+k. The responder assembles them for a 1-, 2- or 4-byte access, in little-endian or big-endian order. The block also owns the lazy return to direct array mode. A first-cycle command write moves it out of direct mode. Once the block has seen more than `LAZY_LIMIT` reads with no sequence in progress, it flags direct mode again, so the surrounding system can go back to its fast array path.

A small state machine tracks direct mode. `LZ_DIRECT` moves to `LZ_COUNTING` on a first-cycle write. `LZ_COUNTING` stays put and clears its count on another first-cycle write, and adds one for each read made while no sequence is in progress. When the read that takes the count past `LAZY_LIMIT` arrives, it returns to `LZ_DIRECT`. Reads are sorted into kinds: array, ident, status, query and unknown.

Top module: `flash_read_responder`

## Requirements
- R1: After reset `rd_valid` and `seq_reset` are 0, `direct_mode` is 1, and the held status byte is 0x00, so the first status read returns 0x00.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` high, and 0 otherwise. `rd_data` holds that read's result in the same cycle.
- R3: With command code 0x00 (read) or 0x80 (erase setup), the result is array data. For width 1 it is lane 0. For width 2 it is {lane1,lane0} when `rd_big_endian`=0 and {lane0,lane1} when it is 1. For width 4 it is {lane3..lane0} in little-endian order, or {lane0..lane3} in big-endian order. Unused upper bits are 0.
- R4: With command code 0x90, take the word offset as `rd_offset` shifted right by log2(`DEV_BYTES`). Offset 0 returns `ID_W0`, offset 1 returns `ID_W1` and offset 2 returns 0. Offset 0x0E returns `ID_W2` and offset 0x0F returns `ID_W3`, but a word that is all ones gives array data instead. Every other offset gives array data.
- R5: With command code 0xA0, 0x10 or 0x30, a read returns the held status byte, and afterwards bit 6 of that byte is inverted. A `status_load` pulse replaces the byte with `status_value`, and the load wins over a toggle in the same cycle.
- R6: With command code 0x98, a read returns the query-table byte at the word offset, and 0 for offsets of `QUERY_LEN` (0x52) and above. The table holds 'Q','R','Y' at 0x10..0x12 and 0x02 at 0x13.
- R7: `direct_mode` goes to 0 on the cycle after `cmd_first_wr`. In `LZ_COUNTING`, each read with `seq_busy`=0 and no `cmd_first_wr` is counted. The read that would make the count exceed `LAZY_LIMIT` returns the block to direct mode on the next cycle, so with the default limit that is the 43rd read. Reads made with `seq_busy`=1 are not counted.
- R8: A read under any other command code returns array data as in R3, and `seq_reset` is 1 in the cycle that `rd_valid` is 1.
- R9: A read with `rd_width` other than 1, 2 or 4 returns all ones.
- R10: Ident, status and query results are zero-extended to 32 bits. For a 1-byte access they are cut to their low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_offset | input | 8 | Low byte address of the read |
| rd_width | input | 3 | Access width in bytes (1, 2 or 4) |
| rd_big_endian | input | 1 | 1 selects big-endian byte assembly |
| cmd_mode | input | 8 | Current command code from the sequencer |
| seq_busy | input | 1 | A write sequence is in progress |
| cmd_first_wr | input | 1 | First-cycle command write seen |
| status_load | input | 1 | Load `status_value` into the held status byte |
| status_value | input | 8 | New status byte |
| arr_bytes | input | 32 | Array bytes at the read address, lane k = address+k |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | `rd_data` is valid |
| seq_reset | output | 1 | Request to the sequencer to return to read mode |
| direct_mode | output | 1 | Direct array-read mode flag |

## Verification
Every read result (`rd_data`, `rd_valid` and `seq_reset`) is registered once, so it is due in the cycle after the strobe. The driver pushes each expected item into a queue as it raises `rd_en`. The monitor pops one item on the falling edge after the next rising edge, and treats a valid with an empty queue as a failure. The status toggle and the `direct_mode` change also take effect at that same rising edge. The bench therefore checks them on the next falling edge: through the result of the following status read, and by sampling `direct_mode` directly.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

    typedef enum logic [2:0] {
        RK_ARRAY,
        RK_IDENT,
        RK_STATUS,
        RK_QUERY,
        RK_BAD
    } rd_kind_e;

    localparam logic [7:0] MODE_READ         = 8'h00;
    localparam logic [7:0] MODE_ERASE_SETUP  = 8'h80;
    localparam logic [7:0] MODE_AUTOSELECT   = 8'h90;
    localparam logic [7:0] MODE_PROGRAM      = 8'hA0;
    localparam logic [7:0] MODE_CHIP_ERASE   = 8'h10;
    localparam logic [7:0] MODE_SECTOR_ERASE = 8'h30;
    localparam logic [7:0] MODE_QUERY        = 8'h98;

    function automatic rd_kind_e classify_mode(input logic [7:0] code);
        rd_kind_e k;
        case (code)
            MODE_READ, MODE_ERASE_SETUP:                    k = RK_ARRAY;
            MODE_AUTOSELECT:                                k = RK_IDENT;
            MODE_PROGRAM, MODE_CHIP_ERASE, MODE_SECTOR_ERASE: k = RK_STATUS;
            MODE_QUERY:                                     k = RK_QUERY;
            default:                                        k = RK_BAD;
        endcase
        return k;
    endfunction

    function automatic logic width_ok(input logic [2:0] w);
        return (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
    endfunction

    // lane k of lanes is the byte at address+k
    function automatic logic [31:0] pack_array(input logic [31:0] lanes,
                                               input logic [2:0]  w,
                                               input logic        big);
        logic [31:0] r;
        r = 32'h0;
        case (w)
            3'd1: r = {24'h0, lanes[7:0]};
            3'd2: r = big ? {16'h0, lanes[7:0], lanes[15:8]}
                          : {16'h0, lanes[15:0]};
            3'd4: r = big ? {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]}
                          : lanes;
            default: r = 32'hFFFF_FFFF;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] fit_narrow(input logic [15:0] v,
                                               input logic [2:0]  w);
        return (w == 3'd1) ? {24'h0, v[7:0]} : {16'h0, v};
    endfunction

endpackage

// File: rtl/flrd_query_rom.sv
module flrd_query_rom #(
    parameter int SECTOR_BYTES = 65536,
    parameter int SECTOR_COUNT = 16,
    parameter int QUERY_LEN    = 82
) (
    input  logic [7:0] idx,
    output logic [7:0] data
);
    localparam int          CHIP_LOG2 = $clog2(SECTOR_BYTES * SECTOR_COUNT);
    localparam logic [31:0] REGION_M1 = 32'(SECTOR_COUNT - 1);
    localparam logic [31:0] SECT_SZ   = 32'(SECTOR_BYTES);

    logic [7:0] raw;

    always_comb begin
        case (idx)
            8'h10: raw = 8'h51;   // 'Q'
            8'h11: raw = 8'h52;   // 'R'
            8'h12: raw = 8'h59;   // 'Y'
            8'h13: raw = 8'h02;
            8'h15: raw = 8'h31;
            8'h1B: raw = 8'h27;
            8'h1C: raw = 8'h36;
            8'h1F: raw = 8'h07;
            8'h21: raw = 8'h09;
            8'h22: raw = 8'h0C;
            8'h23: raw = 8'h01;
            8'h25: raw = 8'h0A;
            8'h26: raw = 8'h0D;
            8'h27: raw = 8'(CHIP_LOG2);
            8'h28: raw = 8'h02;
            8'h2C: raw = 8'h01;
            8'h2D: raw = REGION_M1[7:0];
            8'h2E: raw = REGION_M1[15:8];
            8'h2F: raw = SECT_SZ[15:8];
            8'h30: raw = SECT_SZ[23:16];
            8'h31: raw = 8'h50;   // 'P'
            8'h32: raw = 8'h52;   // 'R'
            8'h33: raw = 8'h49;   // 'I'
            8'h34: raw = 8'h31;   // '1'
            8'h35: raw = 8'h30;   // '0'
            default: raw = 8'h00;
        endcase
        data = (32'(idx) >= QUERY_LEN) ? 8'h00 : raw;
    end

    always_comb begin
        AST_QUERY_PAST_END: assert ((32'(idx) < QUERY_LEN) || (data == 8'h00)); // R6
    end

endmodule

// File: rtl/flrd_status.sv
module flrd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] value,
    input  logic       toggle,
    output logic [7:0] status_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 8'h00;
        end else if (load) begin
            status_q <= value;
        end else if (toggle) begin
            status_q[6] <= ~status_q[6];
        end
    end

    AST_STATUS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !load) |=> (status_q[6] != $past(status_q[6]))); // R5

    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (status_q == $past(value))); // R5

endmodule

// File: rtl/flrd_lazy.sv
module flrd_lazy #(
    parameter int LIMIT = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first_wr,
    input  logic rd_en,
    input  logic seq_busy,
    output logic direct_mode
);
    localparam int CNT_W = $clog2(LIMIT + 1) + 1;

    typedef enum logic {
        LZ_DIRECT,
        LZ_COUNTING
    } lz_state_e;

    lz_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             idle_read;

    assign idle_read = rd_en && !seq_busy && !first_wr;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            LZ_DIRECT: begin
                if (first_wr) begin
                    state_d = LZ_COUNTING;
                    count_d = '0;
                end
            end
            LZ_COUNTING: begin
                if (first_wr) begin
                    count_d = '0;
                end else if (idle_read) begin
                    if (count_q == CNT_W'(LIMIT)) begin
                        state_d = LZ_DIRECT;
                        count_d = '0;
                    end else begin
                        count_d = count_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LZ_DIRECT;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        direct_mode = (state_q == LZ_DIRECT);
    end

    AST_LAZY_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(LIMIT)); // R7

    AST_WRITE_LEAVES_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> !direct_mode); // R7

    AST_BUSY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && seq_busy && !first_wr) |=> !direct_mode); // R7

endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder #(
    parameter int          DEV_BYTES    = 2,
    parameter int          SECTOR_BYTES = 65536,
    parameter int          SECTOR_COUNT = 16,
    parameter int          QUERY_LEN    = 82,
    parameter int          LAZY_LIMIT   = 42,
    parameter logic [15:0] ID_W0        = 16'h0001,
    parameter logic [15:0] ID_W1        = 16'h227E,
    parameter logic [15:0] ID_W2        = 16'h2220,
    parameter logic [15:0] ID_W3        = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [7:0]  rd_offset,
    input  logic [2:0]  rd_width,
    input  logic        rd_big_endian,
    input  logic [7:0]  cmd_mode,
    input  logic        seq_busy,
    input  logic        cmd_first_wr,
    input  logic        status_load,
    input  logic [7:0]  status_value,
    input  logic [31:0] arr_bytes,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        seq_reset,
    output logic        direct_mode
);
    import flrd_pkg::*;

    localparam int OFF_SHIFT = $clog2(DEV_BYTES);

    rd_kind_e    kind;
    logic [7:0]  word_off;
    logic [7:0]  query_byte;
    logic [7:0]  status_q;
    logic [31:0] array_word;
    logic [31:0] result_d;
    logic        status_rd;

    always_comb begin
        kind       = classify_mode(cmd_mode);
        word_off   = rd_offset >> OFF_SHIFT;
        array_word = pack_array(arr_bytes, rd_width, rd_big_endian);
        status_rd  = rd_en && (kind == RK_STATUS);
    end

    flrd_query_rom #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .SECTOR_COUNT (SECTOR_COUNT),
        .QUERY_LEN    (QUERY_LEN)
    ) u_rom (
        .idx  (word_off),
        .data (query_byte)
    );

    flrd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (status_load),
        .value    (status_value),
        .toggle   (status_rd),
        .status_q (status_q)
    );

    flrd_lazy #(
        .LIMIT (LAZY_LIMIT)
    ) u_lazy (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_wr    (cmd_first_wr),
        .rd_en       (rd_en),
        .seq_busy    (seq_busy),
        .direct_mode (direct_mode)
    );

    always_comb begin
        result_d = array_word;
        unique case (kind)
            RK_ARRAY, RK_BAD: result_d = array_word;
            RK_IDENT: begin
                case (word_off)
                    8'h00: result_d = fit_narrow(ID_W0, rd_width);
                    8'h01: result_d = fit_narrow(ID_W1, rd_width);
                    8'h02: result_d = 32'h0;
                    8'h0E: result_d = (&ID_W2) ? array_word : fit_narrow(ID_W2, rd_width);
                    8'h0F: result_d = (&ID_W3) ? array_word : fit_narrow(ID_W3, rd_width);
                    default: result_d = array_word;
                endcase
            end
            RK_STATUS: result_d = fit_narrow({8'h00, status_q}, rd_width);
            RK_QUERY:  result_d = fit_narrow({8'h00, query_byte}, rd_width);
            default:   result_d = array_word;
        endcase
        if (!width_ok(rd_width)) begin
            result_d = 32'hFFFF_FFFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            seq_reset <= 1'b0;
            rd_data   <= 32'h0;
        end else begin
            rd_valid  <= rd_en;
            seq_reset <= rd_en && (kind == RK_BAD);
            if (rd_en) begin
                rd_data <= result_d;
            end
        end
    end

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R2

    AST_RESET_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        seq_reset |-> rd_valid); // R8

    AST_BAD_WIDTH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !width_ok(rd_width)) |=> (rd_data == 32'hFFFF_FFFF)); // R9

    AST_BYTE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_width == 3'd1) |=> (rd_data[31:8] == 24'h0)); // R10

endmodule

// File: tb/sim_flash_read_responder.sv
module sim_flash_read_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_offset = 8'h0;
    logic [2:0]  rd_width = 3'd1;
    logic        rd_big_endian = 1'b0;
    logic [7:0]  cmd_mode = 8'h00;
    logic        seq_busy = 1'b0;
    logic        cmd_first_wr = 1'b0;
    logic        status_load = 1'b0;
    logic [7:0]  status_value = 8'h00;
    logic [31:0] arr_bytes = 32'h0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        seq_reset;
    logic        direct_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        rst;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    flash_read_responder u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_offset(rd_offset),
        .rd_width(rd_width), .rd_big_endian(rd_big_endian), .cmd_mode(cmd_mode),
        .seq_busy(seq_busy), .cmd_first_wr(cmd_first_wr), .status_load(status_load),
        .status_value(status_value), .arr_bytes(arr_bytes), .rd_data(rd_data),
        .rd_valid(rd_valid), .seq_reset(seq_reset), .direct_mode(direct_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one result is due on the falling edge after each strobe
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected valid", 32'(rd_valid), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, rd_data, e.data);
                check({e.tag, " seq_reset R8"}, 32'(seq_reset), 32'(e.rst));
            end
        end
    end

    // driver: called right after a falling edge
    task automatic rd(input logic [7:0] mode, input logic [7:0] off, input logic [2:0] w,
                      input logic be, input logic [31:0] arr, input logic busy,
                      input logic [31:0] exp, input logic exp_rst, input string tag);
        exp_t e;
        cmd_mode = mode; rd_offset = off; rd_width = w; rd_big_endian = be;
        arr_bytes = arr; seq_busy = busy; rd_en = 1'b1;
        e.data = exp; e.rst = exp_rst; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b0; seq_busy = 1'b0;
    endtask

    task automatic load_status(input logic [7:0] v);
        status_value = v; status_load = 1'b1;
        @(negedge clk);
        status_load = 1'b0;
    endtask

    task automatic first_write();
        cmd_first_wr = 1'b1;
        @(negedge clk);
        cmd_first_wr = 1'b0;
    endtask

    localparam logic [31:0] ARR = 32'hDDCCBBAA;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 rd_valid", 32'(rd_valid), 32'h0);
        check("R1 seq_reset", 32'(seq_reset), 32'h0);
        check("R1 direct_mode", 32'(direct_mode), 32'h1);
        rd(8'hA0, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'h00, 1'b0, "R1 status after reset");
        // R5 toggle
        rd(8'hA0, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'h40, 1'b0, "R5 toggle 1");
        rd(8'h10, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'h00, 1'b0, "R5 toggle 2");
        load_status(8'hFF);
        rd(8'h30, 8'h00, 3'd2, 1'b0, ARR, 1'b0, 32'hFF, 1'b0, "R5 loaded");
        rd(8'h30, 8'h00, 3'd2, 1'b0, ARR, 1'b0, 32'hBF, 1'b0, "R5 after load toggle");
        // R3 array assembly
        rd(8'h00, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'h000000AA, 1'b0, "R3 w1");
        rd(8'h00, 8'h00, 3'd2, 1'b0, ARR, 1'b0, 32'h0000BBAA, 1'b0, "R3 w2 le");
        rd(8'h00, 8'h00, 3'd2, 1'b1, ARR, 1'b0, 32'h0000AABB, 1'b0, "R3 w2 be");
        rd(8'h80, 8'h04, 3'd4, 1'b0, ARR, 1'b0, 32'hDDCCBBAA, 1'b0, "R3 w4 le erase setup");
        rd(8'h00, 8'h04, 3'd4, 1'b1, ARR, 1'b0, 32'hAABBCCDD, 1'b0, "R3 w4 be");
        // R4 ident (DEV_BYTES=2 -> word offset = byte offset / 2)
        rd(8'h90, 8'h00, 3'd2, 1'b0, ARR, 1'b0, 32'h0001, 1'b0, "R4 id0");
        rd(8'h90, 8'h02, 3'd2, 1'b0, ARR, 1'b0, 32'h227E, 1'b0, "R4 id1");
        rd(8'h90, 8'h04, 3'd2, 1'b0, ARR, 1'b0, 32'h0000, 1'b0, "R4 protect");
        rd(8'h90, 8'h1C, 3'd2, 1'b0, ARR, 1'b0, 32'h2220, 1'b0, "R4 id2");
        rd(8'h90, 8'h1E, 3'd2, 1'b0, ARR, 1'b0, 32'hBBAA, 1'b0, "R4 id3 all ones");
        rd(8'h90, 8'h06, 3'd2, 1'b1, ARR, 1'b0, 32'hAABB, 1'b0, "R4 other offset");
        rd(8'h90, 8'h02, 3'd1, 1'b0, ARR, 1'b0, 32'h7E, 1'b0, "R10 id1 byte");
        // R6 query
        rd(8'h98, 8'h20, 3'd2, 1'b0, ARR, 1'b0, 32'h51, 1'b0, "R6 Q");
        rd(8'h98, 8'h22, 3'd2, 1'b0, ARR, 1'b0, 32'h52, 1'b0, "R6 R");
        rd(8'h98, 8'h24, 3'd2, 1'b0, ARR, 1'b0, 32'h59, 1'b0, "R6 Y");
        rd(8'h98, 8'h26, 3'd2, 1'b0, ARR, 1'b0, 32'h02, 1'b0, "R6 set code");
        rd(8'h98, 8'hC0, 3'd2, 1'b0, ARR, 1'b0, 32'h00, 1'b0, "R6 past end");
        // R8 unknown mode
        rd(8'h55, 8'h00, 3'd2, 1'b1, ARR, 1'b0, 32'hAABB, 1'b1, "R8 unknown mode");
        // R9 bad width
        rd(8'h00, 8'h00, 3'd3, 1'b0, ARR, 1'b0, 32'hFFFFFFFF, 1'b0, "R9 width 3");
        rd(8'h90, 8'h00, 3'd0, 1'b0, ARR, 1'b0, 32'hFFFFFFFF, 1'b0, "R9 width 0");
        // R7 lazy return
        check("R7 direct before write", 32'(direct_mode), 32'h1);
        first_write();
        check("R7 left direct", 32'(direct_mode), 32'h0);
        for (int i = 0; i < 5; i++) begin
            rd(8'h00, 8'h00, 3'd1, 1'b0, 32'(i), 1'b1, 32'(i), 1'b0, "R7 busy read");
        end
        for (int i = 0; i < 42; i++) begin
            rd(8'h00, 8'h00, 3'd1, 1'b0, 32'(i + 8), 1'b0, 32'(i + 8), 1'b0, "R7 idle read");
        end
        check("R7 still counting after 42", 32'(direct_mode), 32'h0);
        rd(8'h00, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'hAA, 1'b0, "R7 idle read 43");
        check("R7 direct after 43", 32'(direct_mode), 32'h1);
        first_write();
        for (int i = 0; i < 10; i++) begin
            rd(8'h00, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'hAA, 1'b0, "R7 read");
        end
        first_write();
        for (int i = 0; i < 40; i++) begin
            rd(8'h00, 8'h00, 3'd1, 1'b0, ARR, 1'b0, 32'hAA, 1'b0, "R7 read after clear");
        end
        check("R7 write clears count", 32'(direct_mode), 32'h0);
        repeat (3) @(negedge clk);
        check("R2 all results seen", 32'(sb.size()), 32'h0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule